// File: doc/BRIEF.md
# Serial NAND Command Frame Engine

This block runs one complete chip-select-framed transaction towards a serial NAND flash device over a single-bit SPI link in mode 0. A frame is made of up to four phases that always go out in one fixed order: a command byte, zero or more address bytes, zero or more dummy bytes, and one data phase that either sends or receives a programmable number of bytes. Any phase after the command byte with a count of zero is left out, and chip select stays low from the first bit to the last.

The host loads a command description in one request: the command byte, a packed array of address bytes, the three phase counts and the data direction. The engine answers with a one-cycle acknowledge, then works through the frame. Bytes to be sent are read from a byte port, and each one it takes is reported with a strobe. Received bytes are presented with a valid strobe, and a done pulse marks the end of the frame. The host builds the device-specific address layouts itself: an identification read with two returned bytes, one-byte register selects for feature reads and writes, three-byte row addresses, and column addresses that carry a plane bit.

Top module: `spi_nand_frame`

## Requirements
- R1: While reset is asserted and after it is released with no request, chip select is high (inactive), SCLK is low, and ack, done, rx_valid and tx_take are low.
- R2: The bytes on MOSI are sent MSB first in this order: the command byte, then address byte i taken from addr_bytes[8*i+7:8*i] for i counting up from 0, then dummy bytes of value 0x00, then the data bytes. Transmitted data bytes are the successive values of tx_data, and during a receive phase MOSI carries 0x00.
- R3: A frame has exactly 8*(1 + addr_cnt + dummy_cnt + data_len) SCLK rising edges, so a phase with a count of zero adds no clocks.
- R4: Chip select falls once and rises once per frame and stays low across every phase. SCLK is low whenever chip select is high (mode 0 idle level).
- R5: MOSI changes only while SCLK is low and holds steady across every SCLK high period. MISO is sampled on the rising SCLK edge.
- R6: In a receive frame (data_rx = 1) every received byte, MSB first, is presented on rx_data with a one-cycle rx_valid pulse, data_len pulses in total. A transmit frame gives no rx_valid pulses.
- R7: In a transmit frame (data_rx = 0) tx_take pulses once for each data byte taken from tx_data, data_len pulses in total, and the host then presents the next byte. A receive frame gives no tx_take pulses.
- R8: done is a single-cycle pulse per frame, raised in the same cycle that chip select returns high, with SCLK low.
- R9: Chip select stays high for at least 2*DIV_HALF clock cycles (one SCLK period) between two frames, even when the next request is already waiting.
- R10: A request seen while idle is acknowledged by exactly one ack pulse, raised in the same cycle that chip select falls.
- R11: Frames for the device command shapes come out unchanged: an identification read (0x9F) returning two bytes, a feature read or write (0x0F / 0x1F) with one register-select byte and one data byte, a row command with the bytes {0x00, page high, page low}, and cache reads and writes whose first column byte has page bit 6 ORed into bit 4 and whose read form carries 0xFF as its third address byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 1 | Frame request, held until ack |
| ack | output | 1 | One-cycle pulse when the request is taken |
| opcode | input | 8 | Command byte |
| addr_bytes | input | 8*MAX_ADDR | Address bytes, byte 0 sent first |
| addr_cnt | input | $clog2(MAX_ADDR+1) | Number of address bytes (clamped to MAX_ADDR) |
| dummy_cnt | input | $clog2(MAX_DUMMY+1) | Number of dummy bytes (clamped to MAX_DUMMY) |
| data_len | input | LEN_W | Number of data bytes |
| data_rx | input | 1 | 1 = receive data phase, 0 = transmit data phase |
| tx_data | input | 8 | Next byte to transmit |
| tx_take | output | 1 | Pulse after tx_data has been taken |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| done | output | 1 | One-cycle pulse at the end of the frame |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The ack pulse and the falling chip select appear one clock after the request is seen, and each received byte and tx_take appear one clock after the SCLK falling edge that ends the byte. done comes in the same clock that chip select rises, so the last rx_valid and done are due together. The bench collects these strobes on the falling clock edge into counters and only compares them after it has seen done, so no check depends on guessing the exact edge at which a result comes out. MOSI bits are captured on the rising SCLK edge, the device model moves MISO by the count of SCLK rises, and the chip select high time between frames is counted in clock cycles, so a frame issued straight after the previous done tests the minimum gap.

// File: rtl/spinf_pkg.sv
package spinf_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_OPC   = 3'd1,
    PH_ADDR  = 3'd2,
    PH_DUMMY = 3'd3,
    PH_DATA  = 3'd4,
    PH_GAP   = 3'd5
  } phase_e;

  localparam logic [7:0] FILL_BYTE = 8'h00;

endpackage

// File: rtl/spinf_tick.sv
module spinf_tick #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);

  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q == CW'(DIV_HALF - 1));

  always_comb begin
    if (!en)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/spinf_shifter.sv
module spinf_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic [7:0] rx_byte,
  output logic       byte_end
);

  logic       sclk_q, sclk_d;
  logic       busy_q, busy_d;
  logic [2:0] bit_q, bit_d;
  logic [7:0] tx_sr_q, tx_sr_d;
  logic [7:0] rx_sr_q, rx_sr_d;

  // last falling edge of the eighth bit
  assign byte_end = busy_q && tick && sclk_q && (bit_q == 3'd7);
  assign sclk     = sclk_q;
  assign mosi     = tx_sr_q[7];
  assign rx_byte  = rx_sr_q;

  always_comb begin
    sclk_d  = sclk_q;
    busy_d  = busy_q;
    bit_d   = bit_q;
    tx_sr_d = tx_sr_q;
    rx_sr_d = rx_sr_q;
    if (busy_q && tick) begin
      if (!sclk_q) begin
        sclk_d  = 1'b1;
        rx_sr_d = {rx_sr_q[6:0], miso};
      end else begin
        sclk_d = 1'b0;
        if (bit_q == 3'd7) begin
          busy_d = 1'b0;
        end else begin
          tx_sr_d = {tx_sr_q[6:0], 1'b0};
          bit_d   = bit_q + 3'd1;
        end
      end
    end
    if (load) begin
      tx_sr_d = load_byte;
      bit_d   = 3'd0;
      busy_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      busy_q  <= 1'b0;
      bit_q   <= 3'd0;
      tx_sr_q <= 8'h00;
      rx_sr_q <= 8'h00;
    end else begin
      sclk_q  <= sclk_d;
      busy_q  <= busy_d;
      bit_q   <= bit_d;
      tx_sr_q <= tx_sr_d;
      rx_sr_q <= rx_sr_d;
    end
  end

  // R5: the data line holds while the clock is high
  a_r5_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(tx_sr_q[7]));

endmodule

// File: rtl/spinf_seq.sv
module spinf_seq
  import spinf_pkg::*;
#(
  parameter int MAX_ADDR  = 4,
  parameter int MAX_DUMMY = 3,
  parameter int LEN_W     = 12,
  parameter int DIV_HALF  = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req,
  input  logic [7:0]                      opcode,
  input  logic [8*MAX_ADDR-1:0]           addr_bytes,
  input  logic [$clog2(MAX_ADDR+1)-1:0]   addr_cnt,
  input  logic [$clog2(MAX_DUMMY+1)-1:0]  dummy_cnt,
  input  logic [LEN_W-1:0]                data_len,
  input  logic                            data_rx,
  input  logic [7:0]                      tx_data,
  input  logic                            tick,
  input  logic                            byte_end,
  input  logic [7:0]                      rx_byte,
  output logic                            ack,
  output logic                            tx_take,
  output logic [7:0]                      rx_data,
  output logic                            rx_valid,
  output logic                            done,
  output logic                            cs_n,
  output logic                            en,
  output logic                            load,
  output logic [7:0]                      load_byte
);

  localparam int AW      = $clog2(MAX_ADDR + 1);
  localparam int DW      = $clog2(MAX_DUMMY + 1);
  localparam int GAP_MIN = 2 * DIV_HALF;
  localparam int GW      = $clog2(GAP_MIN + 1);

  phase_e                phase_q, phase_d;
  logic [8*MAX_ADDR-1:0] addr_q, addr_d;
  logic [AW-1:0]         a_left_q, a_left_d, a_idx_q, a_idx_d;
  logic [DW-1:0]         d_left_q, d_left_d;
  logic [LEN_W-1:0]      x_left_q, x_left_d;
  logic                  rx_q, rx_d;
  logic                  gap_q, gap_d;
  logic                  cs_n_q, cs_n_d, en_q, en_d;
  logic                  ack_q, ack_d, done_q, done_d;
  logic                  take_q, take_d, rxv_q, rxv_d;
  logic [7:0]            rxd_q, rxd_d;

  always_comb begin
    phase_d   = phase_q;
    addr_d    = addr_q;
    a_left_d  = a_left_q;
    a_idx_d   = a_idx_q;
    d_left_d  = d_left_q;
    x_left_d  = x_left_q;
    rx_d      = rx_q;
    gap_d     = gap_q;
    cs_n_d    = cs_n_q;
    en_d      = en_q;
    ack_d     = 1'b0;
    done_d    = 1'b0;
    take_d    = 1'b0;
    rxv_d     = 1'b0;
    rxd_d     = rxd_q;
    load      = 1'b0;
    load_byte = FILL_BYTE;
    case (phase_q)
      PH_IDLE: begin
        if (req) begin
          ack_d     = 1'b1;
          load      = 1'b1;
          load_byte = opcode;
          addr_d    = addr_bytes;
          a_left_d  = (addr_cnt > AW'(MAX_ADDR)) ? AW'(MAX_ADDR) : addr_cnt;
          d_left_d  = (dummy_cnt > DW'(MAX_DUMMY)) ? DW'(MAX_DUMMY) : dummy_cnt;
          x_left_d  = data_len;
          rx_d      = data_rx;
          a_idx_d   = '0;
          cs_n_d    = 1'b0;
          en_d      = 1'b1;
          phase_d   = PH_OPC;
        end
      end
      PH_OPC, PH_ADDR, PH_DUMMY, PH_DATA: begin
        if (byte_end) begin
          if ((phase_q == PH_DATA) && rx_q) begin
            rxv_d = 1'b1;
            rxd_d = rx_byte;
          end
          if (a_left_q != '0) begin
            load      = 1'b1;
            load_byte = addr_q[8*int'(a_idx_q) +: 8];
            a_left_d  = a_left_q - 1'b1;
            a_idx_d   = a_idx_q + 1'b1;
            phase_d   = PH_ADDR;
          end else if (d_left_q != '0) begin
            load      = 1'b1;
            load_byte = FILL_BYTE;
            d_left_d  = d_left_q - 1'b1;
            phase_d   = PH_DUMMY;
          end else if (x_left_q != '0) begin
            load      = 1'b1;
            load_byte = rx_q ? FILL_BYTE : tx_data;
            take_d    = !rx_q;
            x_left_d  = x_left_q - 1'b1;
            phase_d   = PH_DATA;
          end else begin
            cs_n_d  = 1'b1;
            done_d  = 1'b1;
            gap_d   = 1'b0;
            phase_d = PH_GAP;
          end
        end
      end
      PH_GAP: begin
        if (tick) begin
          if (gap_q) begin
            phase_d = PH_IDLE;
            en_d    = 1'b0;
          end else begin
            gap_d = 1'b1;
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      addr_q   <= '0;
      a_left_q <= '0;
      a_idx_q  <= '0;
      d_left_q <= '0;
      x_left_q <= '0;
      rx_q     <= 1'b0;
      gap_q    <= 1'b0;
      cs_n_q   <= 1'b1;
      en_q     <= 1'b0;
      ack_q    <= 1'b0;
      done_q   <= 1'b0;
      take_q   <= 1'b0;
      rxv_q    <= 1'b0;
      rxd_q    <= 8'h00;
    end else begin
      phase_q  <= phase_d;
      addr_q   <= addr_d;
      a_left_q <= a_left_d;
      a_idx_q  <= a_idx_d;
      d_left_q <= d_left_d;
      x_left_q <= x_left_d;
      rx_q     <= rx_d;
      gap_q    <= gap_d;
      cs_n_q   <= cs_n_d;
      en_q     <= en_d;
      ack_q    <= ack_d;
      done_q   <= done_d;
      take_q   <= take_d;
      rxv_q    <= rxv_d;
      rxd_q    <= rxd_d;
    end
  end

  assign ack      = ack_q;
  assign done     = done_q;
  assign tx_take  = take_q;
  assign rx_valid = rxv_q;
  assign rx_data  = rxd_q;
  assign cs_n     = cs_n_q;
  assign en       = en_q;

  // checker state: cycles of chip select high, saturating
  logic [GW-1:0] gap_mon_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    gap_mon_q <= GW'(GAP_MIN);
    else if (!cs_n_q)                              gap_mon_q <= '0;
    else if (gap_mon_q < GW'(GAP_MIN))             gap_mon_q <= gap_mon_q + 1'b1;
  end

  // R9: one full SCLK period of deselect before a new frame
  a_r9_gap_min: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_q) |-> (gap_mon_q >= GW'(GAP_MIN)));

  // R6: received bytes are separated by a whole byte time
  a_r6_rx_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    rxv_q |=> !rxv_q);

endmodule

// File: rtl/spi_nand_frame.sv
module spi_nand_frame #(
  parameter int MAX_ADDR  = 4,
  parameter int MAX_DUMMY = 3,
  parameter int LEN_W     = 12,
  parameter int DIV_HALF  = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req,
  output logic                            ack,
  input  logic [7:0]                      opcode,
  input  logic [8*MAX_ADDR-1:0]           addr_bytes,
  input  logic [$clog2(MAX_ADDR+1)-1:0]   addr_cnt,
  input  logic [$clog2(MAX_DUMMY+1)-1:0]  dummy_cnt,
  input  logic [LEN_W-1:0]                data_len,
  input  logic                            data_rx,
  input  logic [7:0]                      tx_data,
  output logic                            tx_take,
  output logic [7:0]                      rx_data,
  output logic                            rx_valid,
  output logic                            done,
  output logic                            spi_sclk,
  output logic                            spi_cs_n,
  output logic                            spi_mosi,
  input  logic                            spi_miso
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic       tick, en, load, byte_end;
  logic [7:0] load_byte, rx_byte;

  spinf_tick #(.DIV_HALF(DIV_HALF)) u_tick (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .en    (en),
    .tick  (tick)
  );

  spinf_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .tick      (tick),
    .load      (load),
    .load_byte (load_byte),
    .miso      (spi_miso),
    .sclk      (spi_sclk),
    .mosi      (spi_mosi),
    .rx_byte   (rx_byte),
    .byte_end  (byte_end)
  );

  spinf_seq #(
    .MAX_ADDR  (MAX_ADDR),
    .MAX_DUMMY (MAX_DUMMY),
    .LEN_W     (LEN_W),
    .DIV_HALF  (DIV_HALF)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .req        (req),
    .opcode     (opcode),
    .addr_bytes (addr_bytes),
    .addr_cnt   (addr_cnt),
    .dummy_cnt  (dummy_cnt),
    .data_len   (data_len),
    .data_rx    (data_rx),
    .tx_data    (tx_data),
    .tick       (tick),
    .byte_end   (byte_end),
    .rx_byte    (rx_byte),
    .ack        (ack),
    .tx_take    (tx_take),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .done       (done),
    .cs_n       (spi_cs_n),
    .en         (en),
    .load       (load),
    .load_byte  (load_byte)
  );

  // R4: serial clock rests low while deselected
  a_r4_sclk_idle: assert property (@(posedge clk) disable iff (!rst_sync_q)
    spi_cs_n |-> !spi_sclk);

  // R8: frame end coincides with deselect, clock low
  a_r8_done_deselect: assert property (@(posedge clk) disable iff (!rst_sync_q)
    done |-> (spi_cs_n && !spi_sclk));

  // R10: acknowledge comes with the select edge
  a_r10_ack_select: assert property (@(posedge clk) disable iff (!rst_sync_q)
    ack |-> !spi_cs_n);

endmodule

// File: tb/tb_spi_nand_frame.sv
`timescale 1ns/1ps
module tb_spi_nand_frame;

  localparam int MAX_ADDR  = 4;
  localparam int MAX_DUMMY = 3;
  localparam int LEN_W     = 12;
  localparam int DIV_HALF  = 2;
  localparam int AW        = $clog2(MAX_ADDR + 1);
  localparam int DW        = $clog2(MAX_DUMMY + 1);

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic                  req;
  logic                  ack;
  logic [7:0]            opcode;
  logic [8*MAX_ADDR-1:0] addr_bytes;
  logic [AW-1:0]         addr_cnt;
  logic [DW-1:0]         dummy_cnt;
  logic [LEN_W-1:0]      data_len;
  logic                  data_rx;
  logic [7:0]            tx_data;
  logic                  tx_take;
  logic [7:0]            rx_data;
  logic                  rx_valid;
  logic                  done;
  logic                  spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  always #4 clk = ~clk;

  spi_nand_frame #(
    .MAX_ADDR(MAX_ADDR), .MAX_DUMMY(MAX_DUMMY), .LEN_W(LEN_W), .DIV_HALF(DIV_HALF)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .ack(ack), .opcode(opcode),
    .addr_bytes(addr_bytes), .addr_cnt(addr_cnt), .dummy_cnt(dummy_cnt),
    .data_len(data_len), .data_rx(data_rx), .tx_data(tx_data), .tx_take(tx_take),
    .rx_data(rx_data), .rx_valid(rx_valid), .done(done), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int tests = 0;
  int fails = 0;

  function automatic logic [7:0] txpat(input int s, input int k);
    return 8'((k * 37 + s) ^ 8'h5A);
  endfunction

  function automatic logic [7:0] rxpat(input int k);
    return 8'(8'hC3 + k * 29);
  endfunction

  function automatic logic rxbit(input int n);
    logic [7:0] b;
    b = rxpat(n >> 3);
    return b[3'(7 - (n & 7))];
  endfunction

  // monitor state
  int         bitn, ack_n, done_n, rxn, txn, rises, cs_viol, mosi_viol;
  int         hi_run, last_gap, seed;
  logic       cs_prev, mosi_rise;
  logic [7:0] cap   [0:15];
  logic [7:0] rxcap [0:15];

  // device model: MISO follows the count of SCLK rises in the frame
  assign spi_miso = rxbit(bitn);
  assign tx_data  = txpat(seed, txn);

  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      if (bitn < 128) cap[bitn >> 3][3'(7 - (bitn & 7))] = spi_mosi;
      mosi_rise = spi_mosi;
      bitn++;
    end
  end

  always @(negedge clk) begin
    if (ack) ack_n++;
    if (done) begin
      done_n++;
      if (!spi_cs_n) cs_viol++;
    end
    if (rx_valid) begin
      if (rxn < 16) rxcap[rxn] = rx_data;
      rxn++;
    end
    if (tx_take) txn++;
    if (spi_cs_n && spi_sclk) cs_viol++;
    if (spi_sclk && (spi_mosi !== mosi_rise)) mosi_viol++;
    if (!cs_prev && spi_cs_n) rises++;
    if (spi_cs_n) hi_run++;
    else if (cs_prev) begin
      last_gap = hi_run;
      hi_run   = 0;
    end
    cs_prev = spi_cs_n;
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic run_frame(input string tag, input logic [7:0] op, input int na,
                           input logic [31:0] ab, input int nd, input int nx,
                           input bit rxm, input int s);
    logic [7:0] ex [0:15];
    int nb, bad;
    @(negedge clk);
    bitn = 0; ack_n = 0; done_n = 0; rxn = 0; txn = 0;
    rises = 0; cs_viol = 0; mosi_viol = 0; seed = s;
    opcode     = op;
    addr_bytes = ab;
    addr_cnt   = AW'(na);
    dummy_cnt  = DW'(nd);
    data_len   = LEN_W'(nx);
    data_rx    = rxm;
    req        = 1'b1;
    while (ack_n == 0) @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    while (done_n == 0) @(posedge clk);
    #1;
    nb = 1 + na + nd + nx;
    ex[0] = op;
    for (int i = 0; i < na; i++) ex[1 + i] = ab[8*i +: 8];
    for (int i = 0; i < nd; i++) ex[1 + na + i] = 8'h00;
    for (int j = 0; j < nx; j++) ex[1 + na + nd + j] = rxm ? 8'h00 : txpat(s, j);

    chk(ack_n == 1, "R10", {tag, " ack pulses"}, ack_n, 1);
    chk(bitn == 8 * nb, "R3", {tag, " sclk rises"}, bitn, 8 * nb);
    bad = 0;
    for (int k = 0; k < nb; k++) if (cap[k] !== ex[k]) begin
      if (bad == 0) $display("  byte %0d on mosi: %02h, expected %02h", k, cap[k], ex[k]);
      bad++;
    end
    chk(bad == 0, "R2", {tag, " mosi byte mismatches"}, bad, 0);
    chk(rises == 1, "R4", {tag, " select rises"}, rises, 1);
    chk(cs_viol == 0, "R4", {tag, " sclk high while deselected"}, cs_viol, 0);
    chk(mosi_viol == 0, "R5", {tag, " mosi moved with sclk high"}, mosi_viol, 0);
    if (rxm) begin
      chk(rxn == nx, "R6", {tag, " rx_valid pulses"}, rxn, nx);
      bad = 0;
      for (int j = 0; j < nx && j < 16; j++)
        if (rxcap[j] !== rxpat(1 + na + nd + j)) bad++;
      chk(bad == 0, "R6", {tag, " rx byte mismatches"}, bad, 0);
      chk(txn == 0, "R7", {tag, " tx_take in receive frame"}, txn, 0);
    end else begin
      chk(txn == nx, "R7", {tag, " tx_take pulses"}, txn, nx);
      chk(rxn == 0, "R6", {tag, " rx_valid in transmit frame"}, rxn, 0);
    end
    chk(done_n == 1, "R8", {tag, " done pulses"}, done_n, 1);
    chk(last_gap >= 2 * DIV_HALF, "R9", {tag, " deselect gap"}, last_gap, 2 * DIV_HALF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] page;
    logic [11:0] col;
    bitn = 0; seed = 0; txn = 0; rxn = 0; ack_n = 0; done_n = 0;
    hi_run = 0; last_gap = 0; cs_prev = 1'b1; mosi_rise = 1'b0;
    rises = 0; cs_viol = 0; mosi_viol = 0;
    rst_n = 1'b0; req = 1'b0; opcode = 8'h00; addr_bytes = '0;
    addr_cnt = '0; dummy_cnt = '0; data_len = '0; data_rx = 1'b0;
    repeat (4) @(negedge clk);
    // R1: state held in reset
    chk(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R1", "select/sclk in reset",
        {spi_cs_n, spi_sclk}, 2);
    chk({ack, done, rx_valid, tx_take} === 4'b0, "R1", "strobes in reset",
        {ack, done, rx_valid, tx_take}, 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R1", "select/sclk idle after reset",
        {spi_cs_n, spi_sclk}, 2);
    chk({ack, done, rx_valid, tx_take} === 4'b0, "R1", "strobes idle after reset",
        {ack, done, rx_valid, tx_take}, 0);

    // R11: device command shapes
    run_frame("R11 id read", 8'h9F, 0, 32'h0, 0, 2, 1'b1, 1);
    run_frame("R11 feature get", 8'h0F, 1, 32'h0000_00C0, 0, 1, 1'b1, 2);
    run_frame("R11 feature set", 8'h1F, 1, 32'h0000_00A0, 0, 1, 1'b0, 3);
    page = 16'h1234;
    run_frame("R11 row command", 8'h13, 3, {8'h00, page[7:0], page[15:8], 8'h00},
              0, 0, 1'b0, 4);
    page = 16'h0045; col = 12'h812;
    run_frame("R11 cache read", 8'h03, 3,
              {8'h00, 8'hFF, col[7:0], 8'({page[6], col[11:8]} | 8'h00) | 8'(page[6] << 4) & 8'h1F},
              0, 4, 1'b1, 5);
    page = 16'h0040; col = 12'h034;
    run_frame("R11 cache write", 8'h84, 2,
              {16'h0000, col[7:0], 8'(col[11:8]) | 8'(page[6] << 4)},
              0, 3, 1'b0, 6);

    // sweep of every phase-count combination, both directions
    for (int na = 0; na <= MAX_ADDR; na++)
      for (int nd = 0; nd <= MAX_DUMMY; nd++)
        for (int nx = 0; nx <= 3; nx++)
          for (int d = 0; d < 2; d++)
            run_frame("sweep", 8'(8'h40 + na * 16 + nd * 4 + nx), na,
                      32'h1F2E3D4C ^ (nd * 32'h01010101) ^ (nx * 32'h10204080),
                      nd, nx, d[0], na * 7 + nd * 3 + nx);

    repeat (10) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule